// File: doc/BRIEF.md
# Multi-Window Hit Accept Gate

This block decides, on every sample clock, whether the current sample of one digitizer channel falls inside a segment that a trigger has selected. It keeps up to four trigger windows at once, each in its own comparator slot. Each slot stores a begin time and an end time, and it stretches both edges outward by a coarse resolving margin. A free-running 16-bit time stamp, which counts sample clocks, is compared against the stretched bounds. The hit detector supplies a hit-valid flag and a hit time. A slot accepts a sample only when a valid hit arrived before that window's unstretched end time.

A controller loads a window with a single-cycle load strobe that carries a 2-bit slot index, the begin time, the end time and the margin. The slot computes its bounds from these values at load time. A slot frees itself once the time stamp reaches its stretched end. A clear input empties every slot.

Windows may overlap. The registered accept output is high when any slot accepts. The window index output reports the lowest-numbered slot that accepts and is zero when nothing accepts.

Each slot runs a two-state machine:
- SLOT_IDLE (empty) moves to SLOT_ARMED on **load**.
- SLOT_ARMED moves back to SLOT_IDLE on **clear** or **expire**. Expire means the time stamp is at or past the stretched end.
- SLOT_ARMED stays in SLOT_ARMED on **reload**, which replaces the stored bounds.

Top module: `hit_accept_gate`

## Requirements
- R1: After reset, accept and the window index are 0, and no slot is armed, so no sample is accepted until a window is loaded.
- R2: A load strobe with index i arms slot i from the clock edge that samples it, so a sample presented in the load cycle is not judged against the new window. The margin is captured at load, and later changes on the margin input have no effect on an armed slot.
- R3: The stretched begin equals begin minus margin, saturating at 0. A slot accepts only when the time stamp is strictly greater than the stretched begin.
- R4: The stretched end equals end plus margin, saturating at 65535. A slot accepts only when the time stamp is strictly less than the stretched end.
- R5: A slot accepts only when hit-valid is 1 and the hit time is strictly less than that slot's unstretched end time.
- R6: Accept is the OR of all slots. The window index is the lowest accepting slot number, and it is 0 when accept is 0.
- R7: Accept and the window index are registered. Both reflect the inputs sampled at the preceding rising edge.
- R8: An armed slot whose stretched end is less than or equal to the time stamp at a rising edge becomes empty. After that it never accepts again until it is reloaded, even if the time stamp returns into its range.
- R9: Clear empties all slots at the next edge. Accept is 0 in the cycle after clear is sampled. Clear wins over a load in the same cycle.
- R10: Loading an already armed slot replaces its bounds, and the old range no longer accepts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Empty all window slots |
| ts | input | 16 | Free-running time stamp |
| hit_vld | input | 1 | Hit detector reports a hit |
| hit_time | input | 16 | Time of the reported hit |
| ld_en | input | 1 | Load strobe for one window slot |
| ld_idx | input | 2 | Slot selected by the load |
| ld_begin | input | 16 | Trigger window begin time |
| ld_end | input | 16 | Trigger window end time |
| ld_margin | input | 16 | Coarse resolving margin |
| accept | output | 1 | Sample belongs to a selected segment |
| win_idx | output | 2 | Lowest accepting slot |

## Verification
Accept and the window index are due one rising edge after the time stamp and hit inputs that produce them. A load or clear changes slot state at the edge that samples it, so its effect on accept appears one edge later still. The bench drives every input shortly after a rising edge and reads the outputs 1 ns after the next rising edge. Each check therefore sees exactly the result of the inputs it drove. The load-cycle and clear-cycle checks sample that same edge to show that the new slot state does not yet apply.

// File: rtl/hag_pkg.sv
package hag_pkg;
    typedef enum logic {
        SLOT_IDLE  = 1'b0,
        SLOT_ARMED = 1'b1
    } slot_state_e;
endpackage

// File: rtl/hag_slot.sv
module hag_slot
    import hag_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [TW-1:0] ld_begin,
    input  logic [TW-1:0] ld_end,
    input  logic [TW-1:0] ld_margin,
    input  logic [TW-1:0] ts,
    input  logic          hit_vld,
    input  logic [TW-1:0] hit_time,
    output logic          armed,
    output logic          hit
);
    localparam logic [TW-1:0] TMAX = {TW{1'b1}};

    slot_state_e   state_q, state_d;
    logic [TW-1:0] acc_lo_q, acc_hi_q, trig_hi_q;
    logic [TW-1:0] lo_calc, hi_calc;
    logic [TW:0]   hi_sum;
    logic          expire;

    always_comb begin
        hi_sum  = {1'b0, ld_end} + {1'b0, ld_margin};
        hi_calc = hi_sum[TW] ? TMAX : hi_sum[TW-1:0];
        lo_calc = (ld_margin > ld_begin) ? '0 : (ld_begin - ld_margin);
    end

    assign expire = (ts >= acc_hi_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE:  if (!clr && load) state_d = SLOT_ARMED;
            SLOT_ARMED: begin
                if (clr)         state_d = SLOT_IDLE;
                else if (load)   state_d = SLOT_ARMED;
                else if (expire) state_d = SLOT_IDLE;
            end
            default:    state_d = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= SLOT_IDLE;
            acc_lo_q  <= '0;
            acc_hi_q  <= '0;
            trig_hi_q <= '0;
        end else begin
            state_q <= state_d;
            if (!clr && load) begin
                acc_lo_q  <= lo_calc;
                acc_hi_q  <= hi_calc;
                trig_hi_q <= ld_end;
            end
        end
    end

    always_comb begin
        armed = (state_q == SLOT_ARMED);
        hit   = armed && hit_vld && (hit_time < trig_hi_q)
                && (ts > acc_lo_q) && (ts < acc_hi_q);
    end

    // R2
    load_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> armed);

    // R9
    clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !armed);
endmodule

// File: rtl/hag_pick.sv
module hag_pick #(
    parameter int NW = 4,
    localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic [NW-1:0] req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int k = NW - 1; k >= 0; k--) begin
            if (req[k]) idx = IW'(k);
        end
    end
endmodule

// File: rtl/hit_accept_gate.sv
module hit_accept_gate #(
    parameter int TW = 16,
    parameter int NW = 4,
    localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [TW-1:0] ts,
    input  logic          hit_vld,
    input  logic [TW-1:0] hit_time,
    input  logic          ld_en,
    input  logic [IW-1:0] ld_idx,
    input  logic [TW-1:0] ld_begin,
    input  logic [TW-1:0] ld_end,
    input  logic [TW-1:0] ld_margin,
    output logic          accept,
    output logic [IW-1:0] win_idx
);
    logic [NW-1:0] slot_hit;
    logic [NW-1:0] slot_armed;
    logic          any_hit;
    logic [IW-1:0] pick_idx;

    for (genvar g = 0; g < NW; g++) begin : g_slot
        hag_slot #(.TW(TW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .load      (ld_en && (ld_idx == IW'(g))),
            .ld_begin  (ld_begin),
            .ld_end    (ld_end),
            .ld_margin (ld_margin),
            .ts        (ts),
            .hit_vld   (hit_vld),
            .hit_time  (hit_time),
            .armed     (slot_armed[g]),
            .hit       (slot_hit[g])
        );
    end

    hag_pick #(.NW(NW)) u_pick (
        .req (slot_hit),
        .any (any_hit),
        .idx (pick_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accept  <= 1'b0;
            win_idx <= '0;
        end else begin
            accept  <= any_hit && !clr;
            win_idx <= (any_hit && !clr) ? pick_idx : '0;
        end
    end

    // R5
    no_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_vld |=> !accept);

    // R9
    clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !accept);

    // R6
    idle_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |-> (win_idx == '0));

    // R1
    empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_armed == '0) |=> !accept);
endmodule

// File: tb/tb_hit_accept_gate.sv
module tb_hit_accept_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [15:0] ts = '0;
    logic        hit_vld = 1'b0;
    logic [15:0] hit_time = '0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_idx = '0;
    logic [15:0] ld_begin = '0;
    logic [15:0] ld_end = '0;
    logic [15:0] ld_margin = '0;
    logic        accept;
    logic [1:0]  win_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    hit_accept_gate dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ts(ts), .hit_vld(hit_vld),
        .hit_time(hit_time), .ld_en(ld_en), .ld_idx(ld_idx),
        .ld_begin(ld_begin), .ld_end(ld_end), .ld_margin(ld_margin),
        .accept(accept), .win_idx(win_idx)
    );

    // {ts, hit_vld, hit_time, exp_accept, exp_idx}
    localparam int NV = 13;
    localparam logic [35:0] VEC [NV] = '{
        {16'd90,  1'b1, 16'd95,  1'b0, 2'd0},
        {16'd91,  1'b1, 16'd95,  1'b1, 2'd0},
        {16'd120, 1'b0, 16'd95,  1'b0, 2'd0},
        {16'd120, 1'b1, 16'd200, 1'b0, 2'd0},
        {16'd120, 1'b1, 16'd199, 1'b1, 2'd0},
        {16'd141, 1'b1, 16'd250, 1'b1, 2'd2},
        {16'd160, 1'b1, 16'd10,  1'b1, 2'd0},
        {16'd209, 1'b1, 16'd10,  1'b1, 2'd0},
        {16'd210, 1'b1, 16'd10,  1'b1, 2'd2},
        {16'd150, 1'b1, 16'd10,  1'b1, 2'd2},
        {16'd309, 1'b1, 16'd299, 1'b1, 2'd2},
        {16'd310, 1'b1, 16'd299, 1'b0, 2'd0},
        {16'd200, 1'b1, 16'd10,  1'b0, 2'd0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string req, input logic ea, input logic [1:0] ei);
        n_chk++;
        if (accept !== ea || win_idx !== ei) begin
            n_bad++;
            $display("FAIL %s: accept=%0b idx=%0d expected accept=%0b idx=%0d",
                     req, accept, win_idx, ea, ei);
        end
    endtask

    task automatic load(input logic [1:0] i, input logic [15:0] b,
                        input logic [15:0] e, input logic [15:0] m);
        ld_en = 1'b1; ld_idx = i; ld_begin = b; ld_end = e; ld_margin = m;
        hit_vld = 1'b0; ts = '0;
        tick();
        ld_en = 1'b0;
    endtask

    task automatic probe(input logic [15:0] t, input logic hv, input logic [15:0] ht);
        ts = t; hit_vld = hv; hit_time = ht;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected end of test");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        expect_out("R1 reset", 1'b0, 2'd0);
        rst_n = 1'b1;
        probe(16'd100, 1'b1, 16'd0);
        expect_out("R1 empty slots", 1'b0, 2'd0);

        // table walk: slot0 90..210 trig end 200, slot2 140..310 trig end 300
        load(2'd0, 16'd100, 16'd200, 16'd10);
        load(2'd2, 16'd150, 16'd300, 16'd10);
        for (int v = 0; v < NV; v++) begin
            probe(VEC[v][35:20], VEC[v][19], VEC[v][18:3]);
            expect_out($sformatf("R3/R4/R5/R6/R7/R8 vector %0d", v), VEC[v][2], VEC[v][1:0]);
        end

        // saturation: slot1 bounds 0..65535
        load(2'd1, 16'd5, 16'd65530, 16'd20);
        probe(16'd0, 1'b1, 16'd0);
        expect_out("R3 saturated begin excludes 0", 1'b0, 2'd0);
        probe(16'd1, 1'b1, 16'd0);
        expect_out("R3 saturated begin", 1'b1, 2'd1);
        probe(16'd65534, 1'b1, 16'd0);
        expect_out("R4 saturated end", 1'b1, 2'd1);
        probe(16'd65535, 1'b1, 16'd0);
        expect_out("R4 end excluded", 1'b0, 2'd0);
        probe(16'd100, 1'b1, 16'd0);
        expect_out("R8 expired at max", 1'b0, 2'd0);

        // load latency and captured margin
        ld_en = 1'b1; ld_idx = 2'd0; ld_begin = 16'd10; ld_end = 16'd20; ld_margin = 16'd0;
        ts = 16'd15; hit_vld = 1'b1; hit_time = 16'd0;
        tick();
        ld_en = 1'b0;
        expect_out("R2 not armed in load cycle", 1'b0, 2'd0);
        ld_margin = 16'd100;
        probe(16'd15, 1'b1, 16'd0);
        expect_out("R2 armed after load", 1'b1, 2'd0);
        probe(16'd9, 1'b1, 16'd0);
        expect_out("R2 margin captured", 1'b0, 2'd0);
        probe(16'd25, 1'b1, 16'd0);
        expect_out("R8 slot0 frees", 1'b0, 2'd0);

        // clear
        load(2'd3, 16'd1000, 16'd2000, 16'd0);
        probe(16'd1500, 1'b1, 16'd0);
        expect_out("R6 slot3 alone", 1'b1, 2'd3);
        clr = 1'b1;
        probe(16'd1500, 1'b1, 16'd0);
        clr = 1'b0;
        expect_out("R9 clear cycle", 1'b0, 2'd0);
        probe(16'd1500, 1'b1, 16'd0);
        expect_out("R9 slots emptied", 1'b0, 2'd0);

        // clear beats load
        clr = 1'b1;
        ld_en = 1'b1; ld_idx = 2'd3; ld_begin = 16'd1000; ld_end = 16'd2000; ld_margin = 16'd0;
        hit_vld = 1'b0;
        tick();
        clr = 1'b0; ld_en = 1'b0;
        probe(16'd1500, 1'b1, 16'd0);
        expect_out("R9 clear wins over load", 1'b0, 2'd0);

        // reload replaces bounds
        load(2'd3, 16'd1000, 16'd2000, 16'd0);
        load(2'd3, 16'd3000, 16'd4000, 16'd0);
        probe(16'd1500, 1'b1, 16'd0);
        expect_out("R10 old range gone", 1'b0, 2'd0);
        probe(16'd3500, 1'b1, 16'd0);
        expect_out("R10 new range", 1'b1, 2'd3);
        probe(16'd3500, 1'b0, 16'd0);
        expect_out("R7 drops one edge after hit_vld", 1'b0, 2'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule